// File: doc/BRIEF.md
# Vector-Length Pattern Count Incrementer

This block adds a scaled element count to a 64-bit scalar. A 5-bit pattern code and a 2-bit element-size select together fix how many vector elements are in use at the current vector length. That count is multiplied by a small immediate and added to the scalar. The block handles one request per cycle and returns the sum one cycle later. Instruction decode, register access and enable checks are done elsewhere.

The datapath has three stages in sequence:
- The vector length is legalized and divided by the element size.
- The pattern code becomes a count. The choices are a fixed count, the largest power of two, the largest multiple of four or three, or everything available.
- The count is scaled and added to the operand.

The output register stage is optional and is chosen by a parameter. It is on by default.

Top module: `vlcnt_incr`

## Requirements
- R1: `esize_sel` encodes the element size as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. The available count is the legal vector length divided by that size.
- R2: The vector length is legalized in two steps. Values below 128 become 128 and values above 2048 become 2048. Any other value is rounded down to a multiple of 128.
- R3: Pattern 0 gives the largest power of two that is not above the available count.
- R4: Patterns 1 to 8 request counts 1 to 8. Patterns 9 to 13 request 16, 32, 64, 128 and 256.
- R5: A fixed-count pattern whose requested count exceeds the available count gives a count of zero.
- R6: Pattern 29 gives the largest multiple of 4 not above the available count. Pattern 30 gives the largest multiple of 3 not above it.
- R7: Pattern 31 gives the full available count.
- R8: Patterns 14 to 28 give a count of zero and raise no other indication.
- R9: The multiplier is `mult_field` + 1, which covers 1 to 16.
- R10: `result` is `operand` + count × multiplier, wrapping modulo 2^64.
- R11: With the output stage on, `out_valid` follows `in_valid` by exactly one cycle. Each valid request gives exactly one result, in order.
- R12: Reset clears `out_valid` and `result` to zero. While `in_valid` is low, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| operand | input | 64 | Scalar to increment |
| pattern | input | 5 | Element-count pattern code |
| mult_field | input | 4 | Multiplier minus one |
| esize_sel | input | 2 | Element size select |
| vlen_bits | input | 12 | Current vector length in bits |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Incremented scalar |

## Verification
The assertions on the count relations assume that `pattern`, `esize_sel` and `vlen_bits` are driven to known values from reset onward. The latency and hold properties assume that `in_valid` is never X after reset. The bench meets these assumptions in three ways. It zeroes every input at time zero. It changes inputs only one nanosecond after a rising edge. It drops `in_valid` whenever it is idle. Out-of-range vector lengths are applied on purpose, since the legalizing stage is specified to absorb them.

// File: rtl/vlcnt_pkg.sv
`timescale 1ns/1ps
package vlcnt_pkg;
    localparam int DATA_W   = 64;
    localparam int VL_W     = 12;
    localparam int VL_MIN   = 128;
    localparam int VL_MAX   = 2048;
    localparam int VL_GRAN  = 128;
    localparam int MIN_ES   = 8;
    localparam int CNT_W    = $clog2(VL_MAX / MIN_ES) + 1;
    localparam int MF_W     = 4;
    localparam int MUL_W    = MF_W + 1;
    localparam int PROD_W   = CNT_W + MUL_W;

    typedef enum logic [1:0] {ES_8 = 2'd0, ES_16 = 2'd1, ES_32 = 2'd2, ES_64 = 2'd3} esize_e;

    localparam logic [4:0] PAT_POW2    = 5'd0;
    localparam logic [4:0] PAT_FIX_TOP = 5'd8;
    localparam logic [4:0] PAT_EXP_TOP = 5'd13;
    localparam logic [4:0] PAT_MUL4    = 5'd29;
    localparam logic [4:0] PAT_MUL3    = 5'd30;
    localparam logic [4:0] PAT_ALL     = 5'd31;
endpackage

// File: rtl/vlcnt_avail.sv
`timescale 1ns/1ps
module vlcnt_avail
    import vlcnt_pkg::*;
(
    input  logic [VL_W-1:0]  vl_in,
    input  esize_e           es,
    output logic [VL_W-1:0]  vl_legal,
    output logic [CNT_W-1:0] avail
);
    localparam int GRAN_B = $clog2(VL_GRAN);
    localparam int MIN_SH = $clog2(MIN_ES);

    logic [VL_W-1:0] shifted;
    logic [2:0]      shamt;

    always_comb begin
        if (vl_in < VL_W'(VL_MIN))
            vl_legal = VL_W'(VL_MIN);
        else if (vl_in > VL_W'(VL_MAX))
            vl_legal = VL_W'(VL_MAX);
        else
            vl_legal = {vl_in[VL_W-1:GRAN_B], {GRAN_B{1'b0}}};
    end

    always_comb begin
        shamt   = 3'(MIN_SH) + {1'b0, es};
        shifted = vl_legal >> shamt;
        avail   = shifted[CNT_W-1:0];
    end
endmodule

// File: rtl/vlcnt_pattern.sv
`timescale 1ns/1ps
module vlcnt_pattern
    import vlcnt_pkg::*;
(
    input  logic [4:0]       pat,
    input  logic [CNT_W-1:0] avail,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] pow2, req, fixed_cnt, mul4, mul3;

    // Highest set bit of the available count
    always_comb begin
        pow2 = '0;
        for (int i = 0; i < CNT_W; i++)
            if (avail[i]) pow2 = ONE << i;
    end

    always_comb begin
        if (pat <= PAT_FIX_TOP)
            req = CNT_W'(pat);
        else
            req = ONE << (pat - 5'd5);
        fixed_cnt = (req > avail) ? '0 : req;
        mul4      = {avail[CNT_W-1:2], 2'b00};
        mul3      = avail - (avail % CNT_W'(3));
    end

    always_comb begin
        unique case (pat)
            PAT_POW2:                               cnt = pow2;
            5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6,
            5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12,
            PAT_EXP_TOP:                            cnt = fixed_cnt;
            PAT_MUL4:                               cnt = mul4;
            PAT_MUL3:                               cnt = mul3;
            PAT_ALL:                                cnt = avail;
            default:                                cnt = '0;
        endcase
    end
endmodule

// File: rtl/vlcnt_scale_add.sv
`timescale 1ns/1ps
module vlcnt_scale_add
    import vlcnt_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [MF_W-1:0]   mfield,
    output logic [DATA_W-1:0] sum
);
    logic [MUL_W-1:0]  mult;
    logic [PROD_W-1:0] prod;

    always_comb begin
        mult = {1'b0, mfield} + MUL_W'(1);
        prod = {{MUL_W{1'b0}}, cnt} * {{CNT_W{1'b0}}, mult};
        sum  = operand + {{(DATA_W-PROD_W){1'b0}}, prod};
    end
endmodule

// File: rtl/vlcnt_incr.sv
`timescale 1ns/1ps
module vlcnt_incr
    import vlcnt_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [4:0]        pattern,
    input  logic [MF_W-1:0]   mult_field,
    input  logic [1:0]        esize_sel,
    input  logic [VL_W-1:0]   vlen_bits,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    logic [VL_W-1:0]   vl_legal;
    logic [CNT_W-1:0]  avail, cnt;
    logic [DATA_W-1:0] sum;

    vlcnt_avail u_avail (
        .vl_in(vlen_bits), .es(esize_e'(esize_sel)),
        .vl_legal(vl_legal), .avail(avail)
    );

    vlcnt_pattern u_pat (.pat(pattern), .avail(avail), .cnt(cnt));

    vlcnt_scale_add u_add (
        .operand(operand), .cnt(cnt), .mfield(mult_field), .sum(sum)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    result    <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) result <= sum;
                end
            end

            // R11
            lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R11
            lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R12
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(result));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign result    = sum;
        end
    endgenerate

    // R2
    vl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vl_legal[6:0] == 7'd0 && vl_legal >= VL_W'(VL_MIN) && vl_legal <= VL_W'(VL_MAX));
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= avail);
    // R3
    pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pattern == PAT_POW2 |-> $countones(cnt) == 1 && ({1'b0, cnt} << 1) > {1'b0, avail});
    // R6
    mul4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pattern == PAT_MUL4 |-> cnt[1:0] == 2'b00 && (avail - cnt) < CNT_W'(4));
    // R7
    all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pattern == PAT_ALL |-> cnt == avail);
    // R8
    unassigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern > PAT_EXP_TOP && pattern < PAT_MUL4) |-> cnt == '0);
endmodule

// File: tb/sim_vlcnt_incr.sv
`timescale 1ns/1ps
module sim_vlcnt_incr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [4:0]  pattern = '0;
    logic [3:0]  mult_field = '0;
    logic [1:0]  esize_sel = '0;
    logic [11:0] vlen_bits = '0;
    logic        out_valid;
    logic [63:0] result;

    always #2.5 clk = ~clk;

    vlcnt_incr u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .pattern(pattern), .mult_field(mult_field), .esize_sel(esize_sel),
        .vlen_bits(vlen_bits), .out_valid(out_valid), .result(result)
    );

    typedef struct { logic [63:0] res; string tag; } exp_t;
    exp_t q[$];
    int checks = 0, fails = 0, pushed = 0, popped = 0;
    logic [63:0] last_res = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_model(input logic [63:0] op, input int pat, input int mf,
                                              input int es, input int vl, output string tag);
        int lv, n, c, p;
        lv = vl;
        if (lv < 128) lv = 128;
        else if (lv > 2048) lv = 2048;
        else lv = (lv / 128) * 128;
        n = lv / (8 << es);
        if (pat == 0) begin
            p = 1;
            while (p * 2 <= n) p = p * 2;
            c = p; tag = "R3";
        end else if (pat <= 13) begin
            c = (pat <= 8) ? pat : (16 << (pat - 9));
            if (c > n) begin c = 0; tag = "R5"; end else tag = "R4";
        end else if (pat == 29) begin c = (n / 4) * 4; tag = "R6"; end
        else if (pat == 30) begin c = (n / 3) * 3; tag = "R6"; end
        else if (pat == 31) begin c = n; tag = "R7"; end
        else begin c = 0; tag = "R8"; end
        return op + 64'(c * (mf + 1));
    endfunction

    task automatic send(input logic [63:0] op, input int pat, input int mf,
                        input int es, input int vl, input bit vl_case);
        exp_t e;
        string t;
        @(posedge clk); #1;
        in_valid = 1'b1; operand = op; pattern = 5'(pat);
        mult_field = 4'(mf); esize_sel = 2'(es); vlen_bits = 12'(vl);
        e.res = ref_model(op, pat, mf, es, vl, t);
        e.tag = vl_case ? {"R2 ", t, " R1/R9/R10"} : {t, " R1/R9/R10"};
        q.push_back(e);
        pushed++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; operand = ~operand; pattern = pattern + 5'd1;
        end
    endtask

    // Monitor: pops expected items as results emerge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (q.size() == 0) chk(1'b0, "R11 unexpected out_valid", result, last_res);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    popped++;
                    chk(result === e.res, e.tag, result, e.res);
                end
                last_res = result;
            end else begin
                chk(result === last_res, "R12 hold while idle", result, last_res);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int vls[6] = '{128, 256, 384, 512, 1024, 2048};
        int bad[5] = '{0, 100, 200, 2100, 4095};
        logic [63:0] op;
        int idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R12 reset out_valid", 64'(out_valid), 64'd0);
        chk(result === 64'd0, "R12 reset result", result, 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int v = 0; v < 6; v++)
            for (int es = 0; es < 4; es++)
                for (int pat = 0; pat < 32; pat++)
                    for (int mf = 0; mf < 16; mf++) begin
                        idx++;
                        op = (idx % 7 == 0) ? 64'hFFFF_FFFF_FFFF_FF80 : {32'(idx * 40503), 32'(idx * 7919)};
                        send(op, pat, mf, es, vls[v], 1'b0);
                        if (idx % 97 == 0) idle(2);
                    end
        for (int b = 0; b < 5; b++)
            for (int es = 0; es < 4; es++)
                for (int pat = 0; pat < 32; pat++) begin
                    send(64'hFFFF_FFFF_FFFF_FFFF - 64'(pat), pat, 15, es, bad[b], 1'b1);
                    send(64'(pat * 1000), pat, 0, es, bad[b] + 130 < 4096 ? bad[b] + 130 : bad[b], 1'b1);
                end
        idle(5);
        // R11: every request produced exactly one result
        chk(q.size() == 0 && pushed == popped, "R11 result count", 64'(popped), 64'(pushed));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule